// File: doc/BRIEF.md
# Edge-Triggered One-Shot Pulse Generator

This block turns each qualifying transition on an external input into one delayed output pulse. It does this with two linked down-counter channels. The first channel, the delay channel, sits idle until it sees the chosen edge. It then loads its reload value and counts it down to zero on count-clock ticks. At zero it raises a one-cycle end-of-count strobe.

That strobe retriggers the second channel, the width channel. The width channel loads its own reload value and drives the pulse output to its active level on the next tick. It counts down to zero, then returns the output to its inactive level.

Software starts and stops both channels together with single-cycle trigger strobes. While the channels run, only the edge selection may change; delay, width and polarity are frozen. Both counter values are visible at the ports at all times. Separately, an output-enable bit lets a software-written level drive the pin in place of the pulse.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: After reset, both counters read 0, the block is not running, the end-of-count strobe is low and the pulse output is low.
- R2: A one-cycle `start_stb` enables both channels from the next cycle. Until a qualifying edge is seen, the counters do not change. While stopped, neither counter ever changes.
- R3: The input pin passes through two synchronising flops before edge detection. `edge_sel` selects the qualifying edge: 00 = falling, 01 = rising, 10 = both, 11 = none.
- R4: On a qualifying edge, the delay counter loads the delay value. It then decrements by one on each cycle with `cnt_tick` high. It ignores cycles with `cnt_tick` low. A delay value D spans D+1 ticks before the strobe.
- R5: When the delay counter is 0 on a tick, `eoc_irq` is high for exactly one cycle. The delay counter then holds 0 and waits for the next qualifying edge.
- R6: The cycle after `eoc_irq`, the width counter holds the width value. On the first tick after that, the pulse output goes active.
- R7: When the width counter is 0 on a tick, the output goes inactive and the width channel stops. A width value W keeps the output active for W+1 ticks.
- R8: Every later qualifying edge produces a further strobe and pulse, for as long as the block runs.
- R9: A qualifying edge that arrives while the delay counter is counting is dropped. It is not queued.
- R10: `stop_stb` clears the running state, and it overrides a `start_stb` in the same cycle. Both counters keep their values. The pulse output keeps its level.
- R11: `cfg_wr` (delay, width, polarity) is applied only while the block is stopped and is ignored while running. `edge_wr` is applied at any time.
- R12: When `cfg_act_low` is 1, the active pulse level is low and the inactive level is high. With `lvl_oe` written as 0, the pin shows the software level `lvl_sw`. With `lvl_oe` written as 1, it shows the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count-clock enable; counters move only when high |
| trig_in | input | 1 | Asynchronous trigger input pin |
| start_stb | input | 1 | One-cycle start trigger for both channels |
| stop_stb | input | 1 | One-cycle stop trigger for both channels |
| cfg_wr | input | 1 | Write strobe for delay, width and polarity |
| cfg_delay | input | CNT_W | Delay channel reload value |
| cfg_width | input | CNT_W | Width channel reload value |
| cfg_act_low | input | 1 | 1 = active level is low |
| edge_wr | input | 1 | Write strobe for the edge selection |
| edge_sel | input | 2 | Edge selection code (R3) |
| lvl_wr | input | 1 | Write strobe for output enable and software level |
| lvl_oe | input | 1 | 1 = pin shows pulse, 0 = pin shows software level |
| lvl_sw | input | 1 | Software-written pin level |
| master_cnt | output | CNT_W | Delay counter value |
| slave_cnt | output | CNT_W | Width counter value |
| running | output | 1 | Both channels enabled |
| eoc_irq | output | 1 | One-cycle end-of-delay strobe |
| pulse_out | output | 1 | Pulse output pin |

## Verification
Either channel's state machine can hold a wrong state while its counter is idle, so a corrupted state shows up first as a counter value that differs from the model. This happens within one tick of the next qualifying edge or strobe. A slip in the edge pipeline or in the tick qualification moves the `eoc_irq` cycle. A per-cycle comparison therefore exposes it on the first pulse. Faults in stop and config gating show no symptom until a later pulse takes the wrong width or polarity, so each gating case is followed by a fresh trigger.

// File: rtl/osp_pkg.sv
package osp_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  typedef enum logic {
    M_WAIT  = 1'b0,
    M_COUNT = 1'b1
  } mst_state_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_LOAD  = 2'b01,
    S_COUNT = 2'b10
  } slv_state_e;
endpackage

// File: rtl/osp_edge_det.sv
module osp_edge_det
  import osp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  output logic      edge_o
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q, chain_d;
  logic cur_lvl, prev_lvl, rise, fall;

  generate
    if (CHAIN > 1) begin : g_shift
      assign chain_d = {chain_q[CHAIN-2:0], pin_i};
    end else begin : g_single
      assign chain_d = pin_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign cur_lvl  = chain_q[CHAIN-2];
  assign prev_lvl = chain_q[CHAIN-1];
  assign rise     = cur_lvl & ~prev_lvl;
  assign fall     = ~cur_lvl & prev_lvl;

  always_comb begin
    unique case (sel_i)
      EDGE_FALL: edge_o = fall;
      EDGE_RISE: edge_o = rise;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/osp_master_ch.sv
module osp_master_ch
  import osp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         stop_i,
  input  logic         tick_i,
  input  logic         edge_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         eoc_o
);
  localparam logic [W-1:0] ONE = W'(1);

  mst_state_e   state_q, state_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         eoc_q, eoc_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    eoc_d   = 1'b0;
    if (stop_i) begin
      state_d = M_WAIT;
    end else if (run_i) begin
      unique case (state_q)
        M_WAIT: begin
          if (edge_i) begin
            cnt_d   = reload_i;
            state_d = M_COUNT;
          end
        end
        M_COUNT: begin
          if (tick_i) begin
            if (cnt_q == '0) begin
              eoc_d   = 1'b1;
              state_d = M_WAIT;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: state_d = M_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_WAIT;
      cnt_q   <= '0;
      eoc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      eoc_q   <= eoc_d;
    end
  end

  assign cnt_o = cnt_q;
  assign eoc_o = eoc_q;
endmodule

// File: rtl/osp_slave_ch.sv
module osp_slave_ch
  import osp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         stop_i,
  input  logic         tick_i,
  input  logic         trig_i,
  input  logic [W-1:0] reload_i,
  input  logic         act_lvl_i,
  output logic [W-1:0] cnt_o,
  output logic         out_o
);
  localparam logic [W-1:0] ONE = W'(1);

  slv_state_e   state_q, state_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         out_q, out_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    out_d   = out_q;
    if (stop_i) begin
      state_d = S_IDLE;
    end else if (run_i) begin
      if (trig_i) begin
        cnt_d   = reload_i;
        state_d = S_LOAD;
      end else begin
        unique case (state_q)
          S_LOAD: begin
            if (tick_i) begin
              out_d   = act_lvl_i;
              state_d = S_COUNT;
            end
          end
          S_COUNT: begin
            if (tick_i) begin
              if (cnt_q == '0) begin
                out_d   = ~act_lvl_i;
                state_d = S_IDLE;
              end else begin
                cnt_d = cnt_q - ONE;
              end
            end
          end
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      out_q   <= out_d;
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
  import osp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             trig_in,
  input  logic             start_stb,
  input  logic             stop_stb,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_delay,
  input  logic [CNT_W-1:0] cfg_width,
  input  logic             cfg_act_low,
  input  logic             edge_wr,
  input  logic [1:0]       edge_sel,
  input  logic             lvl_wr,
  input  logic             lvl_oe,
  input  logic             lvl_sw,
  output logic [CNT_W-1:0] master_cnt,
  output logic [CNT_W-1:0] slave_cnt,
  output logic             running,
  output logic             eoc_irq,
  output logic             pulse_out
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] delay_q, delay_d;
  logic [CNT_W-1:0] width_q, width_d;
  logic             act_low_q, act_low_d;
  edge_sel_e        esel_q, esel_d;
  logic             oe_q, oe_d;
  logic             swl_q, swl_d;
  logic             edge_hit;
  logic             slv_out;
  logic             cfg_open;

  assign cfg_open = cfg_wr & ~run_q;

  always_comb begin
    run_d     = run_q;
    delay_d   = delay_q;
    width_d   = width_q;
    act_low_d = act_low_q;
    esel_d    = esel_q;
    oe_d      = oe_q;
    swl_d     = swl_q;
    if (stop_stb)       run_d = 1'b0;
    else if (start_stb) run_d = 1'b1;
    if (cfg_open) begin
      delay_d   = cfg_delay;
      width_d   = cfg_width;
      act_low_d = cfg_act_low;
    end
    if (edge_wr) esel_d = edge_sel_e'(edge_sel);
    if (lvl_wr) begin
      oe_d  = lvl_oe;
      swl_d = lvl_sw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      delay_q   <= '0;
      width_q   <= '0;
      act_low_q <= 1'b0;
      esel_q    <= EDGE_FALL;
      oe_q      <= 1'b0;
      swl_q     <= 1'b0;
    end else begin
      run_q     <= run_d;
      delay_q   <= delay_d;
      width_q   <= width_d;
      act_low_q <= act_low_d;
      esel_q    <= esel_d;
      oe_q      <= oe_d;
      swl_q     <= swl_d;
    end
  end

  osp_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (trig_in),
    .sel_i  (esel_q),
    .edge_o (edge_hit)
  );

  osp_master_ch #(.W(CNT_W)) u_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_q),
    .stop_i   (stop_stb),
    .tick_i   (cnt_tick),
    .edge_i   (edge_hit),
    .reload_i (delay_q),
    .cnt_o    (master_cnt),
    .eoc_o    (eoc_irq)
  );

  osp_slave_ch #(.W(CNT_W)) u_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_q),
    .stop_i    (stop_stb),
    .tick_i    (cnt_tick),
    .trig_i    (eoc_irq),
    .reload_i  (width_q),
    .act_lvl_i (~act_low_q),
    .cnt_o     (slave_cnt),
    .out_o     (slv_out)
  );

  assign running   = run_q;
  assign pulse_out = oe_q ? slv_out : swl_q;
endmodule

// File: rtl/osp_chk.sv
module osp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         running,
  input logic         stop_stb,
  input logic         lvl_wr,
  input logic         eoc_irq,
  input logic         pulse_out,
  input logic [W-1:0] master_cnt,
  input logic [W-1:0] slave_cnt,
  input logic [W-1:0] width_q
);
  // R5
  eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> (!running && master_cnt == $past(master_cnt)
                  && slave_cnt == $past(slave_cnt)));

  // R2
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> ($stable(master_cnt) && $stable(slave_cnt)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !lvl_wr) |=> $stable(pulse_out));

  // R6
  slave_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_irq && running && !stop_stb) |=> (slave_cnt == $past(width_q)));
endmodule

bind oneshot_pulse_gen osp_chk #(.W(CNT_W)) u_osp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .running    (running),
  .stop_stb   (stop_stb),
  .lvl_wr     (lvl_wr),
  .eoc_irq    (eoc_irq),
  .pulse_out  (pulse_out),
  .master_cnt (master_cnt),
  .slave_cnt  (slave_cnt),
  .width_q    (width_q)
);

// File: tb/test_oneshot_pulse_gen.sv
module test_oneshot_pulse_gen;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_tick = 1'b0, trig_in = 1'b0, start_stb = 1'b0, stop_stb = 1'b0;
  logic cfg_wr = 1'b0, cfg_act_low = 1'b0, edge_wr = 1'b0;
  logic [W-1:0] cfg_delay = '0, cfg_width = '0;
  logic [1:0] edge_sel = 2'b00;
  logic lvl_wr = 1'b0, lvl_oe = 1'b0, lvl_sw = 1'b0;
  logic [W-1:0] master_cnt, slave_cnt;
  logic running, eoc_irq, pulse_out;

  always #4 clk = ~clk;

  oneshot_pulse_gen #(.CNT_W(W)) i_oneshot_pulse_gen (.*);

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  int tick_div = 1, tick_ph = 0;
  int irq_n = 0, hi_n = 0, lo_n = 0;

  // behavioural reference model
  int m_h[3];
  int m_run, m_mcount, m_mcnt, m_sst, m_scnt, m_out, m_irq;
  int m_delay, m_width, m_al, m_esel, m_oe, m_swl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = '{0, 0, 0};
      m_run = 0; m_mcount = 0; m_mcnt = 0; m_sst = 0; m_scnt = 0;
      m_out = 0; m_irq = 0; m_delay = 0; m_width = 0; m_al = 0;
      m_esel = 0; m_oe = 0; m_swl = 0;
    end else begin
      automatic int rise = (m_h[1] == 1 && m_h[2] == 0) ? 1 : 0;
      automatic int fall = (m_h[1] == 0 && m_h[2] == 1) ? 1 : 0;
      automatic int ev = (m_esel == 0) ? fall : (m_esel == 1) ? rise :
                         (m_esel == 2) ? (rise | fall) : 0;
      automatic int act = m_al ? 0 : 1;
      automatic int n_irq = 0;
      if (stop_stb) m_mcount = 0;
      else if (m_run != 0) begin
        if (m_mcount == 0) begin
          if (ev != 0) begin m_mcnt = m_delay; m_mcount = 1; end
        end else if (cnt_tick) begin
          if (m_mcnt == 0) begin n_irq = 1; m_mcount = 0; end
          else m_mcnt = m_mcnt - 1;
        end
      end
      if (stop_stb) m_sst = 0;
      else if (m_run != 0) begin
        if (m_irq != 0) begin m_scnt = m_width; m_sst = 1; end
        else if (m_sst == 1 && cnt_tick) begin m_out = act; m_sst = 2; end
        else if (m_sst == 2 && cnt_tick) begin
          if (m_scnt == 0) begin m_out = 1 - act; m_sst = 0; end
          else m_scnt = m_scnt - 1;
        end
      end
      m_irq = n_irq;
      if (cfg_wr && m_run == 0) begin
        m_delay = int'(cfg_delay); m_width = int'(cfg_width); m_al = int'(cfg_act_low);
      end
      if (edge_wr) m_esel = int'(edge_sel);
      if (lvl_wr) begin m_oe = int'(lvl_oe); m_swl = int'(lvl_sw); end
      if (stop_stb) m_run = 0; else if (start_stb) m_run = 1;
      m_h[2] = m_h[1]; m_h[1] = m_h[0]; m_h[0] = int'(trig_in);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic int exp_pin = (m_oe != 0) ? m_out : m_swl;
      checks++;
      if (int'(master_cnt) != m_mcnt || int'(slave_cnt) != m_scnt ||
          int'(running) != m_run || int'(eoc_irq) != m_irq ||
          int'(pulse_out) != exp_pin) begin
        errors++;
        $display("FAIL %s cycle: actual m=%0d s=%0d run=%0d irq=%0d pin=%0d expected m=%0d s=%0d run=%0d irq=%0d pin=%0d",
                 cur_req, master_cnt, slave_cnt, running, eoc_irq, pulse_out,
                 m_mcnt, m_scnt, m_run, m_irq, exp_pin);
      end
      if (eoc_irq) irq_n++;
      if (pulse_out) hi_n++; else lo_n++;
    end
  end

  // tick generator
  always @(negedge clk) begin
    if (tick_div <= 1) begin cnt_tick <= 1'b1; tick_ph <= 0; end
    else begin
      cnt_tick <= (tick_ph == 0);
      tick_ph  <= (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input int d, input int w, input int al);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_delay = W'(d); cfg_width = W'(w); cfg_act_low = al[0];
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_edge(input int e);
    @(negedge clk); edge_wr = 1'b1; edge_sel = e[1:0];
    @(negedge clk); edge_wr = 1'b0;
  endtask

  task automatic wr_lvl(input int oe, input int sw);
    @(negedge clk); lvl_wr = 1'b1; lvl_oe = oe[0]; lvl_sw = sw[0];
    @(negedge clk); lvl_wr = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_stb = 1'b1;
    @(negedge clk); start_stb = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0;
  endtask

  task automatic clr();
    irq_n = 0; hi_n = 0; lo_n = 0;
  endtask

  task automatic pin(input int v, input int n);
    @(negedge clk); trig_in = v[0];
    cyc(n);
  endtask

  initial begin
    logic [W-1:0] hm, hs;
    logic hp;
    int guard;
    cyc(4);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);
    cur_req = "R1";
    chk("R1", "master_cnt", int'(master_cnt), 0);
    chk("R1", "slave_cnt", int'(slave_cnt), 0);
    chk("R1", "running", int'(running), 0);
    chk("R1", "eoc_irq", int'(eoc_irq), 0);
    chk("R1", "pulse_out", int'(pulse_out), 0);

    cur_req = "R2";
    wr_cfg(3, 2, 0);
    wr_lvl(1, 0);
    wr_edge(1);
    do_start();
    cyc(6);
    chk("R2", "running", int'(running), 1);
    chk("R2", "master_cnt idle", int'(master_cnt), 0);

    cur_req = "R7"; clr();
    pin(1, 20);
    chk("R5", "strobe count", irq_n, 1);
    chk("R7", "active cycles W=2", hi_n, 3);
    cur_req = "R3"; clr();
    pin(0, 20);
    chk("R3", "falling ignored under rise", irq_n, 0);

    cur_req = "R8"; clr();
    pin(1, 20);
    chk("R8", "second pulse strobe", irq_n, 1);
    chk("R8", "second pulse width", hi_n, 3);

    cur_req = "R11"; clr();
    wr_cfg(5, 0, 1);
    pin(0, 6);
    pin(1, 20);
    chk("R11", "old width kept", hi_n, 3);
    clr();
    wr_edge(0);
    pin(0, 20);
    chk("R11", "edge select live", irq_n, 1);

    cur_req = "R3"; clr();
    wr_edge(2);
    pin(1, 20);
    pin(0, 20);
    chk("R3", "both edges", irq_n, 2);
    clr();
    wr_edge(3);
    pin(1, 10);
    pin(0, 10);
    chk("R3", "no edge code", irq_n, 0);

    cur_req = "R9";
    do_stop();
    wr_cfg(10, 1, 0);
    wr_edge(1);
    do_start();
    clr();
    pin(1, 4);
    pin(0, 3);
    pin(1, 40);
    chk("R9", "retrigger dropped", irq_n, 1);

    cur_req = "R4"; tick_div = 3; clr();
    pin(0, 6);
    pin(1, 100);
    chk("R4", "strobe with slow tick", irq_n, 1);
    chk("R4", "width in cycles at tick/3", hi_n, 6);
    tick_div = 1;

    cur_req = "R10";
    pin(0, 6);
    @(negedge clk); trig_in = 1'b1;
    guard = 0;
    while (!pulse_out && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk); stop_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0;
    hm = master_cnt; hs = slave_cnt; hp = pulse_out;
    cyc(10);
    chk("R10", "running after stop", int'(running), 0);
    chk("R10", "pulse held", int'(pulse_out), int'(hp));
    chk("R10", "pulse held high", int'(pulse_out), 1);
    chk("R10", "master held", int'(master_cnt), int'(hm));
    chk("R10", "slave held", int'(slave_cnt), int'(hs));
    @(negedge clk); stop_stb = 1'b1; start_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0; start_stb = 1'b0;
    chk("R10", "stop wins over start", int'(running), 0);

    cur_req = "R12";
    pin(0, 4);
    wr_cfg(2, 2, 1);
    do_start();
    clr();
    pin(1, 20);
    chk("R12", "active-low cycles", lo_n, 3);
    chk("R12", "inactive level high", int'(pulse_out), 1);
    wr_lvl(0, 0);
    cyc(1);
    chk("R12", "software level 0", int'(pulse_out), 0);
    wr_lvl(0, 1);
    cyc(1);
    chk("R12", "software level 1", int'(pulse_out), 1);
    wr_lvl(1, 0);
    cyc(1);
    chk("R12", "pulse restored", int'(pulse_out), 1);

    cyc(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule